// File: doc/BRIEF.md
# Event-Driven Match Timer PWM

This block is a pulse-width modulator built around one shared up-counter and a bank of match events. Each event watches one selectable match register. It fires when that register equals the counter. Outputs are not tied to fixed channels. Every output has two event bitmasks, one that drives it high and one that drives it low, plus a 2-bit rule that decides what happens when both masks hit in the same cycle. A limit mask picks the events that return the counter to zero, so a single event sets the period that every output shares.

Software configures the block through a small word-addressed register bus. A prescaler divides the count rate, a halt bit freezes the counter, and every match register has a shadow reload register. The shadow values are copied in at a period boundary, so duty and period changes take effect without glitches. A typical setup uses event 0 as the period/limit event and gives each output its own duty event. For normal polarity the output is set on the period event and cleared on the duty event; for inverted polarity the two masks are swapped.

Top module: `mtpwm_timer`

## Requirements
- R1: After reset every output is low, the counter (read at 0x040) is 0, and the control word at 0x004 reads 0x4, meaning halt (bit 2) is set and the prescale field is 0.
- R2: The counter advances by one once every (P+1) clocks, where P is the prescale field in bits 12:5 of 0x004. It holds its value while halt is set or while the unify bit (bit 0 of 0x000) is clear. Writing 0x040 loads the counter.
- R3: When a firing event has its bit set in the limit mask at 0x008, the counter's next value is 0. A limit event watching match value M therefore gives a period of M+1 counts, and the counter never exceeds M.
- R4: Event n is configured through two registers. Its control word at 0x304+8n selects a match register index in bits 3:0 and has a combine field in bits 13:12. Its state mask is at 0x300+8n. The event fires on a count tick when the combine field equals 1, bit 0 of the state mask is 1, and the selected match register equals the counter. Otherwise the event has no effect.
- R5: Output n has a set mask at 0x500+8n and a clear mask at 0x504+8n, where bit k stands for event k. The output goes high or low one clock after the tick on which a masked event fires. An output with empty masks stays low.
- R6: When set and clear events hit output n on the same tick, bits 2n+1:2n of 0x058 decide the result: 0 keeps the level, 1 sets, 2 clears and 3 toggles.
- R7: Match registers live at 0x100+4n and their reload registers at 0x200+4n. When a limit event fires, every match register takes its reload value, unless bit 7 of 0x000 is set, which disables reloading. A new duty therefore applies from the next period.
- R8: Every configuration register reads back the value that was written, within its implemented fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pwm_out | output | 16 | Modulated outputs |

## Verification
An event is judged on the counter value present during a tick. The output and the counter both change at the edge that ends that tick, so an output level is due one clock after its matching count, and a reload is due at the clock after the limit tick. The bench measures output duty as a high-clock count over a window of exactly one period (or two periods, for the toggle rule), taken only after two settling periods. The result therefore does not depend on phase. Run-length checks begin at a detected rising edge. Counter and register reads are sampled at the falling edge, after the address has settled.

// File: rtl/mtpwm_pkg.sv
package mtpwm_pkg;

    typedef enum logic [1:0] {
        RULE_KEEP = 2'd0,
        RULE_SET  = 2'd1,
        RULE_CLR  = 2'd2,
        RULE_TOG  = 2'd3
    } rule_e;

    // address page in bus_addr[11:8]
    localparam logic [3:0] PG_GLOBAL = 4'h0;
    localparam logic [3:0] PG_MATCH  = 4'h1;
    localparam logic [3:0] PG_RELOAD = 4'h2;
    localparam logic [3:0] PG_EVENT  = 4'h3;
    localparam logic [3:0] PG_OUTPUT = 4'h5;

    // offsets inside the global page
    localparam logic [7:0] OFS_CFG   = 8'h00;
    localparam logic [7:0] OFS_CTRL  = 8'h04;
    localparam logic [7:0] OFS_LIMIT = 8'h08;
    localparam logic [7:0] OFS_COUNT = 8'h40;
    localparam logic [7:0] OFS_RULE  = 8'h58;

    localparam int CFG_UNIFY_BIT   = 0;
    localparam int CFG_NORELOAD_BIT = 7;
    localparam int CTRL_HALT_BIT   = 2;
    localparam int CTRL_PRE_LSB    = 5;
    localparam int EV_COMB_LSB     = 12;

    localparam logic [1:0] COMB_MATCH_ONLY = 2'd1;

endpackage

// File: rtl/mtpwm_regs.sv
module mtpwm_regs
    import mtpwm_pkg::*;
#(
    parameter int NUM_EV    = 16,
    parameter int NUM_MATCH = 16,
    parameter int NUM_OUT   = 16,
    parameter int CNT_W     = 32,
    parameter int PRE_W     = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_sel,
    input  logic                                 bus_we,
    input  logic [11:0]                          bus_addr,
    input  logic [31:0]                          bus_wdata,
    output logic [31:0]                          bus_rdata,
    input  logic [CNT_W-1:0]                     cnt_i,
    input  logic                                 wrap_i,
    output logic                                 run_o,
    output logic [PRE_W-1:0]                     pre_o,
    output logic [NUM_EV-1:0]                    limit_o,
    output logic [2*NUM_OUT-1:0]                 rule_o,
    output logic [NUM_MATCH-1:0][CNT_W-1:0]      match_o,
    output logic [NUM_EV-1:0][$clog2(NUM_MATCH)-1:0] sel_o,
    output logic [NUM_EV-1:0][1:0]               comb_o,
    output logic [NUM_EV-1:0]                    en_o,
    output logic [NUM_OUT-1:0][NUM_EV-1:0]       setm_o,
    output logic [NUM_OUT-1:0][NUM_EV-1:0]       clrm_o,
    output logic                                 cnt_wr_o,
    output logic [CNT_W-1:0]                     cnt_wdata_o
);
    // index fields assume power-of-two counts
    localparam int MIDX_W = $clog2(NUM_MATCH);
    localparam int EIDX_W = $clog2(NUM_EV);
    localparam int OIDX_W = $clog2(NUM_OUT);

    typedef struct packed {
        logic                              unify;
        logic                              norel;
        logic                              halt;
        logic [PRE_W-1:0]                  pre;
        logic [NUM_EV-1:0]                 limit;
        logic [2*NUM_OUT-1:0]              rule;
        logic [NUM_MATCH-1:0][CNT_W-1:0]   match;
        logic [NUM_MATCH-1:0][CNT_W-1:0]   reload;
        logic [NUM_EV-1:0][MIDX_W-1:0]     sel;
        logic [NUM_EV-1:0][1:0]            comb;
        logic [NUM_EV-1:0]                 en;
        logic [NUM_OUT-1:0][NUM_EV-1:0]    setm;
        logic [NUM_OUT-1:0][NUM_EV-1:0]    clrm;
    } regs_t;

    regs_t r_d, r_q;

    logic              wr;
    logic [3:0]        page;
    logic [MIDX_W-1:0] m_idx;
    logic [EIDX_W-1:0] e_idx;
    logic [OIDX_W-1:0] o_idx;

    assign wr    = bus_sel && bus_we && (bus_addr[1:0] == 2'b00);
    assign page  = bus_addr[11:8];
    assign m_idx = bus_addr[2 +: MIDX_W];
    assign e_idx = bus_addr[3 +: EIDX_W];
    assign o_idx = bus_addr[3 +: OIDX_W];

    always_comb begin
        r_d         = r_q;
        cnt_wr_o    = 1'b0;
        cnt_wdata_o = bus_wdata[CNT_W-1:0];
        // shadow copy at the period boundary; a bus write below wins
        if (wrap_i && !r_q.norel) begin
            r_d.match = r_q.reload;
        end
        if (wr) begin
            case (page)
                PG_GLOBAL: begin
                    case (bus_addr[7:0])
                        OFS_CFG: begin
                            r_d.unify = bus_wdata[CFG_UNIFY_BIT];
                            r_d.norel = bus_wdata[CFG_NORELOAD_BIT];
                        end
                        OFS_CTRL: begin
                            r_d.halt = bus_wdata[CTRL_HALT_BIT];
                            r_d.pre  = bus_wdata[CTRL_PRE_LSB +: PRE_W];
                        end
                        OFS_LIMIT: r_d.limit = bus_wdata[NUM_EV-1:0];
                        OFS_RULE:  r_d.rule  = bus_wdata[2*NUM_OUT-1:0];
                        OFS_COUNT: cnt_wr_o  = 1'b1;
                        default: ;
                    endcase
                end
                PG_MATCH:  r_d.match[m_idx]  = bus_wdata[CNT_W-1:0];
                PG_RELOAD: r_d.reload[m_idx] = bus_wdata[CNT_W-1:0];
                PG_EVENT: begin
                    if (bus_addr[2]) begin
                        r_d.sel[e_idx]  = bus_wdata[MIDX_W-1:0];
                        r_d.comb[e_idx] = bus_wdata[EV_COMB_LSB +: 2];
                    end else begin
                        r_d.en[e_idx] = bus_wdata[0];
                    end
                end
                PG_OUTPUT: begin
                    if (bus_addr[2]) r_d.clrm[o_idx] = bus_wdata[NUM_EV-1:0];
                    else             r_d.setm[o_idx] = bus_wdata[NUM_EV-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.halt <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        case (page)
            PG_GLOBAL: begin
                case (bus_addr[7:0])
                    OFS_CFG: begin
                        bus_rdata[CFG_UNIFY_BIT]    = r_q.unify;
                        bus_rdata[CFG_NORELOAD_BIT] = r_q.norel;
                    end
                    OFS_CTRL: begin
                        bus_rdata[CTRL_HALT_BIT]          = r_q.halt;
                        bus_rdata[CTRL_PRE_LSB +: PRE_W]  = r_q.pre;
                    end
                    OFS_LIMIT: bus_rdata[NUM_EV-1:0]    = r_q.limit;
                    OFS_RULE:  bus_rdata[2*NUM_OUT-1:0] = r_q.rule;
                    OFS_COUNT: bus_rdata[CNT_W-1:0]     = cnt_i;
                    default: ;
                endcase
            end
            PG_MATCH:  bus_rdata[CNT_W-1:0] = r_q.match[m_idx];
            PG_RELOAD: bus_rdata[CNT_W-1:0] = r_q.reload[m_idx];
            PG_EVENT: begin
                if (bus_addr[2]) begin
                    bus_rdata[MIDX_W-1:0]          = r_q.sel[e_idx];
                    bus_rdata[EV_COMB_LSB +: 2]    = r_q.comb[e_idx];
                end else begin
                    bus_rdata[0] = r_q.en[e_idx];
                end
            end
            PG_OUTPUT: begin
                if (bus_addr[2]) bus_rdata[NUM_EV-1:0] = r_q.clrm[o_idx];
                else             bus_rdata[NUM_EV-1:0] = r_q.setm[o_idx];
            end
            default: ;
        endcase
    end

    assign run_o   = r_q.unify && !r_q.halt;
    assign pre_o   = r_q.pre;
    assign limit_o = r_q.limit;
    assign rule_o  = r_q.rule;
    assign match_o = r_q.match;
    assign sel_o   = r_q.sel;
    assign comb_o  = r_q.comb;
    assign en_o    = r_q.en;
    assign setm_o  = r_q.setm;
    assign clrm_o  = r_q.clrm;

    // R7: shadow values land in the match bank after a limit event
    p_reload_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !r_q.norel && !(wr && page == PG_MATCH)) |=> (r_q.match == $past(r_q.reload)));

    // R7: with reloading disabled and no bus write, the match bank holds
    p_reload_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.norel && !(wr && page == PG_MATCH)) |=> $stable(r_q.match));

endmodule

// File: rtl/mtpwm_core.sv
module mtpwm_core
    import mtpwm_pkg::*;
#(
    parameter int NUM_EV    = 16,
    parameter int NUM_MATCH = 16,
    parameter int CNT_W     = 32,
    parameter int PRE_W     = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      run_i,
    input  logic [PRE_W-1:0]                          pre_i,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0]           match_i,
    input  logic [NUM_EV-1:0][$clog2(NUM_MATCH)-1:0]  sel_i,
    input  logic [NUM_EV-1:0][1:0]                    comb_i,
    input  logic [NUM_EV-1:0]                         en_i,
    input  logic [NUM_EV-1:0]                         limit_i,
    input  logic                                      cnt_wr_i,
    input  logic [CNT_W-1:0]                          cnt_wdata_i,
    output logic [CNT_W-1:0]                          cnt_o,
    output logic [NUM_EV-1:0]                         fire_o,
    output logic                                      wrap_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre_cnt;
        logic [CNT_W-1:0] cnt;
    } core_t;

    core_t st_d, st_q;
    logic  tick;

    always_comb begin
        tick = run_i && (st_q.pre_cnt >= pre_i);
        for (int e = 0; e < NUM_EV; e++) begin
            fire_o[e] = tick && en_i[e] && (comb_i[e] == COMB_MATCH_ONLY)
                        && (match_i[sel_i[e]] == st_q.cnt);
        end
        wrap_o = |(fire_o & limit_i);

        st_d = st_q;
        if (run_i) begin
            st_d.pre_cnt = tick ? '0 : st_q.pre_cnt + 1'b1;
        end
        if (tick) begin
            st_d.cnt = wrap_o ? '0 : st_q.cnt + 1'b1;
        end
        if (cnt_wr_i) begin
            st_d.cnt = cnt_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R2: a stopped counter keeps its value
    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_wr_i) |=> $stable(cnt_o));

    // R3: a limit event brings the counter back to zero
    p_limit_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !cnt_wr_i) |=> (cnt_o == '0));

    // R4: events only fire while the counter runs
    p_fire_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire_o) |-> run_i);

endmodule

// File: rtl/mtpwm_outs.sv
module mtpwm_outs
    import mtpwm_pkg::*;
#(
    parameter int NUM_EV  = 16,
    parameter int NUM_OUT = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_EV-1:0]               fire_i,
    input  logic [NUM_OUT-1:0][NUM_EV-1:0]  setm_i,
    input  logic [NUM_OUT-1:0][NUM_EV-1:0]  clrm_i,
    input  logic [2*NUM_OUT-1:0]            rule_i,
    output logic [NUM_OUT-1:0]              out_o
);
    typedef struct packed {
        logic [NUM_OUT-1:0] lvl;
    } outs_t;

    outs_t o_d, o_q;
    logic [NUM_OUT-1:0] s_hit, c_hit;

    always_comb begin
        o_d = o_q;
        for (int o = 0; o < NUM_OUT; o++) begin
            s_hit[o] = |(fire_i & setm_i[o]);
            c_hit[o] = |(fire_i & clrm_i[o]);
            if (s_hit[o] && c_hit[o]) begin
                case (rule_e'(rule_i[2*o +: 2]))
                    RULE_SET: o_d.lvl[o] = 1'b1;
                    RULE_CLR: o_d.lvl[o] = 1'b0;
                    RULE_TOG: o_d.lvl[o] = !o_q.lvl[o];
                    default:  o_d.lvl[o] = o_q.lvl[o];
                endcase
            end else if (s_hit[o]) begin
                o_d.lvl[o] = 1'b1;
            end else if (c_hit[o]) begin
                o_d.lvl[o] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_o = o_q.lvl;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
        // R5: a lone set or clear lands one clock later
        p_set_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (s_hit[g] && !c_hit[g]) |=> out_o[g]);
        p_clr_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (c_hit[g] && !s_hit[g]) |=> !out_o[g]);
        // R5: no hit, no change
        p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!s_hit[g] && !c_hit[g]) |=> $stable(out_o[g]));
        // R6: toggle rule flips the level on a collision
        p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (s_hit[g] && c_hit[g] && rule_i[2*g +: 2] == 2'd3) |=> (out_o[g] != $past(out_o[g])));
    end

endmodule

// File: rtl/mtpwm_timer.sv
module mtpwm_timer
    import mtpwm_pkg::*;
#(
    parameter int NUM_EV    = 16,
    parameter int NUM_MATCH = 16,
    parameter int NUM_OUT   = 16,
    parameter int CNT_W     = 32,
    parameter int PRE_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_OUT-1:0] pwm_out
);
    localparam int MIDX_W = $clog2(NUM_MATCH);

    logic                             run;
    logic [PRE_W-1:0]                 pre;
    logic [NUM_EV-1:0]                limit;
    logic [2*NUM_OUT-1:0]             rule;
    logic [NUM_MATCH-1:0][CNT_W-1:0]  match;
    logic [NUM_EV-1:0][MIDX_W-1:0]    sel;
    logic [NUM_EV-1:0][1:0]           comb;
    logic [NUM_EV-1:0]                en;
    logic [NUM_OUT-1:0][NUM_EV-1:0]   setm, clrm;
    logic                             cnt_wr;
    logic [CNT_W-1:0]                 cnt_wdata, cnt;
    logic [NUM_EV-1:0]                fire;
    logic                             wrap;

    mtpwm_regs #(
        .NUM_EV(NUM_EV), .NUM_MATCH(NUM_MATCH), .NUM_OUT(NUM_OUT),
        .CNT_W(CNT_W), .PRE_W(PRE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_i(cnt), .wrap_i(wrap),
        .run_o(run), .pre_o(pre), .limit_o(limit), .rule_o(rule),
        .match_o(match), .sel_o(sel), .comb_o(comb), .en_o(en),
        .setm_o(setm), .clrm_o(clrm),
        .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata)
    );

    mtpwm_core #(
        .NUM_EV(NUM_EV), .NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W), .PRE_W(PRE_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .run_i(run), .pre_i(pre), .match_i(match), .sel_i(sel),
        .comb_i(comb), .en_i(en), .limit_i(limit),
        .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata),
        .cnt_o(cnt), .fire_o(fire), .wrap_o(wrap)
    );

    mtpwm_outs #(
        .NUM_EV(NUM_EV), .NUM_OUT(NUM_OUT)
    ) u_outs (
        .clk(clk), .rst_n(rst_n),
        .fire_i(fire), .setm_i(setm), .clrm_i(clrm), .rule_i(rule),
        .out_o(pwm_out)
    );

endmodule

// File: tb/mtpwm_timer_bench.sv
module mtpwm_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pwm_out;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = !clk;

    mtpwm_timer u_mtpwm_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic int exp_high(input int p, input int d, input int pre, input bit inv);
        int h = d + 1;
        if (inv) h = p - h;
        return h * (pre + 1);
    endfunction

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[0]) h++;
        end
    endtask

    // period event 0 on match 0, duty event 1 on match 1, output 0
    task automatic setup(input int p, input int d, input int pre, input bit inv, input int rule);
        wr(12'h004, 32'h4);
        wr(12'h000, 32'h1);
        wr(12'h040, 32'h0);
        wr(12'h100, p - 1); wr(12'h200, p - 1);
        wr(12'h104, d);     wr(12'h204, d);
        wr(12'h300, 32'h1); wr(12'h304, (32'h1 << 12) | 32'h0);
        wr(12'h308, 32'h1); wr(12'h30C, (32'h1 << 12) | 32'h1);
        wr(12'h008, 32'h1);
        wr(12'h500, inv ? 32'h2 : 32'h1);
        wr(12'h504, inv ? 32'h1 : 32'h2);
        wr(12'h058, rule);
        wr(12'h004, pre << 5);
    endtask

    task automatic wait_rise();
        for (int i = 0; i < 2000 && pwm_out[0]; i++) @(negedge clk);
        for (int i = 0; i < 2000 && !pwm_out[0]; i++) @(negedge clk);
    endtask

    task automatic high_run(output int n);
        n = 0;
        while (pwm_out[0] && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired (R2 progress) actual=150000 expected=fewer cycles");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin : main
        logic [31:0] v, v2;
        int h, p, d, pre, runl;
        bit inv;
        v = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(pwm_out == 16'h0, "R1 outputs low", pwm_out, 0);
        rd(12'h040, v); check(v == 0, "R1 counter zero", v, 0);
        rd(12'h004, v); check(v == 32'h4, "R1 ctrl halted", v, 4);

        // R8 readback
        wr(12'h528, 32'hA5A5); rd(12'h528, v);
        check(v == 32'hA5A5, "R8 set mask out5", v, 32'hA5A5);
        wr(12'h058, 32'h9C3); rd(12'h058, v);
        check(v == 32'h9C3, "R8 rule word", v, 32'h9C3);
        wr(12'h32C, (32'h2 << 12) | 32'h7); rd(12'h32C, v);
        check(v == ((32'h2 << 12) | 32'h7), "R8 event ctrl", v, (32'h2 << 12) | 32'h7);
        wr(12'h528, 32'h0);

        // R5 directed edge timing: high for exactly d+1 clocks
        setup(10, 3, 0, 1'b0, 1);
        repeat (25) @(negedge clk);
        wait_rise(); high_run(runl);
        check(runl == 4, "R5 high run normal", runl, 4);

        // R3 counter bounded by period
        h = 0;
        for (int i = 0; i < 30; i++) begin
            rd(12'h040, v);
            if (v > h) h = v;
        end
        check(h == 9, "R3 counter max", h, 9);

        // R4 disabled event: combine 0 -> duty clear never fires
        wr(12'h30C, 32'h1);
        repeat (25) @(negedge clk);
        count_high(10, h);
        check(h == 10, "R4 combine off", h, 10);
        wr(12'h30C, (32'h1 << 12) | 32'h1);
        wr(12'h308, 32'h0);
        repeat (25) @(negedge clk);
        count_high(10, h);
        check(h == 10, "R4 state mask off", h, 10);
        wr(12'h308, 32'h1);
        repeat (25) @(negedge clk);
        count_high(10, h);
        check(h == 4, "R4 re-enabled", h, 4);

        // R7 duty change waits for the period boundary
        setup(20, 3, 0, 1'b0, 1);
        repeat (45) @(negedge clk);
        wait_rise();
        wr(12'h204, 32'd10);
        rd(12'h104, v);
        check(v == 3, "R7 match not yet reloaded", v, 3);
        wait_rise(); high_run(runl);
        check(runl == 11, "R7 new duty applied", runl, 11);
        wr(12'h000, 32'h81);
        wr(12'h204, 32'd5);
        repeat (65) @(negedge clk);
        rd(12'h104, v);
        check(v == 10, "R7 reload disabled", v, 10);
        wr(12'h000, 32'h1);

        // R6 conflict rules with duty == period
        setup(8, 7, 0, 1'b0, 1);
        repeat (20) @(negedge clk);
        count_high(8, h); check(h == 8, "R6 rule set", h, 8);
        wr(12'h058, 32'h0);
        repeat (20) @(negedge clk);
        count_high(8, h); check(h == 8, "R6 rule keep", h, 8);
        wr(12'h058, 32'h2);
        repeat (20) @(negedge clk);
        count_high(8, h); check(h == 0, "R6 rule clear", h, 0);
        wr(12'h058, 32'h3);
        repeat (20) @(negedge clk);
        count_high(16, h); check(h == 8, "R6 rule toggle", h, 8);

        // R2 halt, unify and prescaler
        setup(1000, 3, 3, 1'b0, 1);
        rd(12'h040, v);
        repeat (7) @(negedge clk);
        rd(12'h040, v2);
        check(v2 == v + 2, "R2 prescale 4", v2, v + 2);
        wr(12'h004, 32'h4);
        rd(12'h040, v); repeat (20) @(negedge clk); rd(12'h040, v2);
        check(v2 == v, "R2 halt holds", v2, v);
        wr(12'h004, 32'h0); wr(12'h000, 32'h0);
        rd(12'h040, v); repeat (20) @(negedge clk); rd(12'h040, v2);
        check(v2 == v, "R2 unify clear holds", v2, v);
        wr(12'h000, 32'h1);
        rd(12'h040, v); repeat (7) @(negedge clk); rd(12'h040, v2);
        check(v2 == v + 8, "R2 prescale 1", v2, v + 8);

        // random duty, period, prescale, polarity
        for (int t = 0; t < 12; t++) begin
            p   = 2 + int'($urandom % 30);
            d   = int'($urandom % (p - 1));
            pre = int'($urandom % 3);
            inv = 1'($urandom % 2);
            setup(p, d, pre, inv, inv ? 2 : 1);
            repeat (3 * p * (pre + 1) + 4) @(negedge clk);
            count_high(p * (pre + 1), h);
            check(h == exp_high(p, d, pre, inv), inv ? "R5 random inverted" : "R5 random normal",
                  h, exp_high(p, d, pre, inv));
        end

        // R5 output with empty masks
        check(pwm_out[2] == 1'b0, "R5 unused output low", pwm_out[2], 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule